// File: doc/BRIEF.md
# Buffered SPI Page Program Engine

This block stages one page of flash data, up to 256 bytes, through a single auto-incrementing data-port register. It then writes the page into a serial flash device as one program frame. A host fills the page, sets the program opcode, the transfer length and a 24-bit page address, and starts the transfer by writing a command to a mode register. The same mode register reports progress. One bit shows that programming is running. Another bit shows that the buffer is empty and ready for a new page.

The engine must first be placed in in-system-programming mode. Once started, it can optionally send a write-enable command (0x06) in its own chip-select window. It then drives one chip-select window that carries the opcode, the three address bytes most significant first, and exactly the requested number of data bytes. The serial clock runs at half the system clock in SPI mode 0.

Top module: `page_prog_engine`

## Requirements
- R1: After reset the mode register (0x6F) reads busy (bit 5) = 0, buffer-empty (bit 4) = 1 and programming-mode (bit 7) = 0. Chip select (active low) is high.
- R2: Writing 0x80 to 0x6F sets programming mode (bit 7 reads 1). Writing 0xA0 to 0x6F starts a transfer only while programming mode is set. Outside that mode the start write is ignored and no chip-select window occurs.
- R3: Each write to data port 0x70 stores its byte at the next buffer location. Data bytes leave on the serial line in the order they were written.
- R4: Register 0x71 holds the page length minus one. 0x00 sends one data byte and 0xFF sends 256. Its reset value is 0xFF.
- R5: The first byte of the program frame is the opcode held in register 0x6D. Its reset value is 0x02.
- R6: Bytes 2 to 4 of the program frame are the address registers 0x64 (bits 23:16), 0x65 (bits 15:8) and 0x66 (bits 7:0), in that order. Each byte is sent MSB first.
- R7: Bit 5 of 0x6F reads 1 from the cycle after an accepted start until chip select of the program frame has been released.
- R8: Bit 4 of 0x6F clears on the first data-port write. It sets again when programming finishes.
- R9: With the preamble enabled, each transfer begins with a one-byte chip-select window carrying 0x06, followed by the program frame in a separate window.
- R10: The data-port write pointer returns to location 0 when a transfer starts and when it completes. The next page therefore loads from location 0.
- R11: The serial clock idles low and toggles at half the system clock. MOSI changes only while the serial clock is low. Each window carries a whole number of bytes.
- R12: While busy, writes to the data port, the configuration registers and the mode register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register write address |
| regWdata | input | 8 | Register write data |
| regRdAddr | input | 8 | Register read address |
| regRdata | output | 8 | Register read data (combinational) |
| spiSck | output | 1 | Serial clock |
| spiCsN | output | 1 | Chip select, active low |
| spiMosi | output | 1 | Serial data to the flash |

## Verification
The assertions check, on every cycle, several rules. Busy may only rise after a start write accepted in programming mode. Busy and buffer-empty must change together at completion. The write pointer is frozen while busy and is back at zero after completion. Every chip-select window closes on a byte boundary. The bench scenarios are the only way to show the frame contents. That covers the opcode, the address order, the exact number of data bytes for the 1-byte and 256-byte lengths, and the preamble window. They also show that writes made while busy leave no trace in a later frame or in the register readback.

// File: rtl/ppe_pkg.sv
package ppe_pkg;
  localparam logic [7:0] REG_ADDR_HI = 8'h64;
  localparam logic [7:0] REG_ADDR_MID = 8'h65;
  localparam logic [7:0] REG_ADDR_LO = 8'h66;
  localparam logic [7:0] REG_OPCODE = 8'h6D;
  localparam logic [7:0] REG_MODE = 8'h6F;
  localparam logic [7:0] REG_DATA = 8'h70;
  localparam logic [7:0] REG_LEN = 8'h71;

  localparam logic [7:0] CMD_ISP = 8'h80;
  localparam logic [7:0] CMD_START = 8'hA0;
  localparam logic [7:0] WREN_OPCODE = 8'h06;

  typedef enum logic [2:0] {
    SEL_WREN, SEL_OPC, SEL_ADR2, SEL_ADR1, SEL_ADR0, SEL_DATA
  } byteSel_t;

  typedef struct packed {
    logic     load;
    logic     shift;
    byteSel_t sel;
    logic     done;
  } ppeStrobe_t;
endpackage

// File: rtl/ppe_ctrl.sv
module ppe_ctrl
  import ppe_pkg::*;
#(
  parameter bit WREN_PREAMBLE = 1'b1,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [LEN_W-1:0] lenM1,
  output ppeStrobe_t       strobe,
  output logic             busy,
  output logic             sck,
  output logic             csN
);
  localparam int BYTE_W = LEN_W + 2;
  localparam logic [BYTE_W-1:0] HDR_BYTES = BYTE_W'(4);

  typedef enum logic [2:0] {ST_IDLE, ST_PRE, ST_GAP, ST_FRAME, ST_FIN} state_t;

  state_t state;
  logic [BYTE_W-1:0] byteIdx;
  logic [BYTE_W-1:0] nextIdx;
  logic [2:0] bitIdx;
  logic phase;
  logic inWindow;
  logic lastByte;
  byteSel_t nextSel;

  assign inWindow = (state == ST_PRE) || (state == ST_FRAME);
  assign nextIdx = byteIdx + BYTE_W'(1);
  assign lastByte = (state == ST_PRE) || (byteIdx == (BYTE_W'(lenM1) + HDR_BYTES));
  assign busy = (state != ST_IDLE);
  assign sck = inWindow && phase;
  assign csN = !inWindow;

  always_comb begin
    case (nextIdx)
      BYTE_W'(1): nextSel = SEL_ADR2;
      BYTE_W'(2): nextSel = SEL_ADR1;
      BYTE_W'(3): nextSel = SEL_ADR0;
      default:    nextSel = SEL_DATA;
    endcase
  end

  always_comb begin
    strobe = '0;
    strobe.sel = SEL_OPC;
    case (state)
      ST_IDLE: if (startReq) begin
        strobe.load = 1'b1;
        strobe.sel = WREN_PREAMBLE ? SEL_WREN : SEL_OPC;
      end
      ST_PRE, ST_FRAME: if (phase) begin
        if (bitIdx != 3'd7) strobe.shift = 1'b1;
        else if (!lastByte) begin
          strobe.load = 1'b1;
          strobe.sel = nextSel;
        end
      end
      ST_GAP: strobe.load = 1'b1;
      ST_FIN: strobe.done = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      byteIdx <= '0;
      bitIdx <= '0;
      phase <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (startReq) begin
          state <= WREN_PREAMBLE ? ST_PRE : ST_FRAME;
          byteIdx <= '0;
          bitIdx <= '0;
          phase <= 1'b0;
        end
        ST_PRE, ST_FRAME: begin
          phase <= !phase;
          if (phase) begin
            if (bitIdx == 3'd7) begin
              bitIdx <= '0;
              if (lastByte) state <= (state == ST_PRE) ? ST_GAP : ST_FIN;
              else byteIdx <= nextIdx;
            end else begin
              bitIdx <= bitIdx + 3'd1;
            end
          end
        end
        ST_GAP: begin
          state <= ST_FRAME;
          byteIdx <= '0;
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker: count serial clock pulses inside each chip-select window
  logic [BYTE_W+2:0] sckCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckCnt <= '0;
    else if (csN) sckCnt <= '0;
    else if (sck) sckCnt <= sckCnt + 1'b1;
  end

  AST_WHOLE_BYTES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> (sckCnt[2:0] == 3'd0) && (sckCnt != '0)); // R11

  AST_SCK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    sck |=> !sck); // R11
endmodule

// File: rtl/ppe_datapath.sv
module ppe_datapath
  import ppe_pkg::*;
#(
  parameter int BUF_DEPTH = 256,
  parameter int PTR_W = $clog2(BUF_DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [7:0]       regAddr,
  input  logic [7:0]       regWdata,
  input  logic [7:0]       regRdAddr,
  output logic [7:0]       regRdata,
  input  ppeStrobe_t       strobe,
  input  logic             busy,
  output logic             startReq,
  output logic [PTR_W-1:0] lenM1,
  output logic             mosi
);
  logic ispMode;
  logic bufEmpty;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [7:0] opcode;
  logic [7:0] addrHi, addrMid, addrLo;
  logic [7:0] sreg;
  logic [7:0] pageBuf [BUF_DEPTH];
  logic cfgWr, dataWr;

  assign cfgWr = regWe && !busy;
  assign dataWr = cfgWr && (regAddr == REG_DATA);
  assign startReq = cfgWr && (regAddr == REG_MODE) && (regWdata == CMD_START) && ispMode;
  assign mosi = sreg[7];

  always_ff @(posedge clk) begin
    if (dataWr) pageBuf[wrPtr] <= regWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ispMode <= 1'b0;
      opcode <= 8'h02;
      lenM1 <= '1;
      addrHi <= '0;
      addrMid <= '0;
      addrLo <= '0;
    end else if (cfgWr) begin
      case (regAddr)
        REG_MODE:     if (regWdata == CMD_ISP) ispMode <= 1'b1;
        REG_OPCODE:   opcode <= regWdata;
        REG_LEN:      lenM1 <= PTR_W'(regWdata);
        REG_ADDR_HI:  addrHi <= regWdata;
        REG_ADDR_MID: addrMid <= regWdata;
        REG_ADDR_LO:  addrLo <= regWdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      bufEmpty <= 1'b1;
    end else if (startReq || strobe.done) begin
      wrPtr <= '0;
      if (strobe.done) bufEmpty <= 1'b1;
    end else if (dataWr) begin
      wrPtr <= wrPtr + 1'b1;
      bufEmpty <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      sreg <= '0;
    end else begin
      if (startReq) rdPtr <= '0;
      if (strobe.load) begin
        case (strobe.sel)
          SEL_WREN: sreg <= WREN_OPCODE;
          SEL_OPC:  sreg <= opcode;
          SEL_ADR2: sreg <= addrHi;
          SEL_ADR1: sreg <= addrMid;
          SEL_ADR0: sreg <= addrLo;
          default: begin
            sreg <= pageBuf[rdPtr];
            rdPtr <= rdPtr + 1'b1;
          end
        endcase
      end else if (strobe.shift) begin
        sreg <= {sreg[6:0], 1'b0};
      end
    end
  end

  always_comb begin
    case (regRdAddr)
      REG_MODE:     regRdata = {ispMode, 1'b0, busy, bufEmpty, 4'b0};
      REG_OPCODE:   regRdata = opcode;
      REG_LEN:      regRdata = 8'(lenM1);
      REG_ADDR_HI:  regRdata = addrHi;
      REG_ADDR_MID: regRdata = addrMid;
      REG_ADDR_LO:  regRdata = addrLo;
      default:      regRdata = 8'h00;
    endcase
  end

  AST_START_NEEDS_ISP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(regWe && regAddr == REG_MODE && regWdata == CMD_START && ispMode)); // R2

  AST_EMPTY_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> bufEmpty); // R8

  AST_PTR_CLEAR_DONE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.done |=> (wrPtr == '0)); // R10

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobe.done && regWe) |=> $stable(wrPtr) && $stable(lenM1) && $stable(opcode)); // R12
endmodule

// File: rtl/page_prog_engine.sv
module page_prog_engine
  import ppe_pkg::*;
#(
  parameter int BUF_DEPTH = 256,
  parameter bit WREN_PREAMBLE = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWdata,
  input  logic [7:0] regRdAddr,
  output logic [7:0] regRdata,
  output logic       spiSck,
  output logic       spiCsN,
  output logic       spiMosi
);
  localparam int PTR_W = $clog2(BUF_DEPTH);

  ppeStrobe_t strobe;
  logic busy;
  logic startReq;
  logic [PTR_W-1:0] lenM1;

  ppe_datapath #(.BUF_DEPTH(BUF_DEPTH), .PTR_W(PTR_W)) i_datapath (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdAddr(regRdAddr), .regRdata(regRdata), .strobe(strobe), .busy(busy),
    .startReq(startReq), .lenM1(lenM1), .mosi(spiMosi)
  );

  ppe_ctrl #(.WREN_PREAMBLE(WREN_PREAMBLE), .LEN_W(PTR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .lenM1(lenM1), .strobe(strobe),
    .busy(busy), .sck(spiSck), .csN(spiCsN)
  );
endmodule

// File: tb/test_page_prog_engine.sv
module test_page_prog_engine;
  localparam time CLK_PERIOD = 20ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [7:0] regAddr = '0, regWdata = '0, regRdAddr = '0;
  logic [7:0] regRdata;
  logic spiSck, spiCsN, spiMosi;

  int nChecks = 0;
  int nFails = 0;

  page_prog_engine i_page_prog_engine (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdAddr(regRdAddr), .regRdata(regRdata),
    .spiSck(spiSck), .spiCsN(spiCsN), .spiMosi(spiMosi)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // SPI monitor, sampled at the falling system clock edge
  logic [7:0] capBuf [300];
  int capLen = 0;
  int bitCnt = 0;
  logic [7:0] curByte = '0;
  int winCount = 0;
  int winLen [8];
  logic [7:0] winFirst [8];
  int modeViol = 0;
  logic prevCsN = 1'b1, prevSck = 1'b0, lowMosi = 1'b0;

  always @(negedge clk) begin
    if (!spiCsN) begin
      if (prevCsN) begin
        capLen = 0;
        bitCnt = 0;
      end
      if (spiSck) begin
        if (prevSck || spiMosi !== lowMosi) modeViol++;
        curByte = {curByte[6:0], spiMosi};
        bitCnt++;
        if (bitCnt == 8) begin
          if (capLen < 300) capBuf[capLen] = curByte;
          capLen++;
          bitCnt = 0;
        end
      end else begin
        lowMosi = spiMosi;
      end
    end else begin
      if (spiSck) modeViol++;
      if (!prevCsN) begin
        if (bitCnt != 0) modeViol++;
        if (winCount < 8) begin
          winLen[winCount] = capLen;
          winFirst[winCount] = capBuf[0];
        end
        winCount++;
      end
    end
    prevCsN = spiCsN;
    prevSck = spiSck;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    regRdAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitIdle();
    logic [7:0] m;
    for (int i = 0; i < 20000; i++) begin
      rd(8'h6F, m);
      if (!m[5]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] patt(input int seed, input int i);
    return 8'(seed + i * 7 + (i >> 3));
  endfunction

  task automatic testReset();
    logic [7:0] m;
    rd(8'h6F, m);
    check(m[5] == 1'b0, "R1 busy", m, 0);
    check(m[4] == 1'b1, "R1 empty", m, 8'h10);
    check(m[7] == 1'b0, "R1 isp", m, 0);
    check(spiCsN == 1'b1, "R1 csN", spiCsN, 1);
    rd(8'h71, m);
    check(m == 8'hFF, "R4 length reset", m, 8'hFF);
    rd(8'h6D, m);
    check(m == 8'h02, "R5 opcode reset", m, 8'h02);
  endtask

  task automatic testStartWithoutIsp();
    logic [7:0] m;
    wr(8'h6F, 8'hA0);
    repeat (40) @(negedge clk);
    rd(8'h6F, m);
    check(m[5] == 1'b0, "R2 start ignored busy", m, 0);
    check(winCount == 0, "R2 no window without isp", winCount, 0);
    wr(8'h6F, 8'h80);
    rd(8'h6F, m);
    check(m[7] == 1'b1, "R2 isp set", m, 8'h80);
  endtask

  task automatic runPage(input int n, input logic [7:0] op, input logic [23:0] addr,
                         input int seed, input bit meddle, input string tag);
    logic [7:0] m;
    int base;
    base = winCount;
    wr(8'h6D, op);
    wr(8'h71, 8'(n - 1));
    wr(8'h64, addr[23:16]);
    wr(8'h65, addr[15:8]);
    wr(8'h66, addr[7:0]);
    for (int i = 0; i < n; i++) begin
      wr(8'h70, patt(seed, i));
      if (i == 0) begin
        rd(8'h6F, m);
        check(m[4] == 1'b0, {"R8 empty clears ", tag}, m, 0);
      end
    end
    wr(8'h6F, 8'hA0);
    rd(8'h6F, m);
    check(m[5] == 1'b1, {"R7 busy after start ", tag}, m, 8'h20);
    if (meddle) begin
      for (int i = 0; i < 5; i++) wr(8'h70, 8'hEE);
      wr(8'h71, 8'h03);
      wr(8'h6D, 8'h99);
      wr(8'h6F, 8'hA0);
    end
    waitIdle();
    rd(8'h6F, m);
    check(m[5] == 1'b0, {"R7 busy cleared ", tag}, m, 0);
    check(m[4] == 1'b1, {"R8 empty after done ", tag}, m, 8'h10);
    check(winCount - base == 2, {"R9/R12 window count ", tag}, winCount - base, 2);
    check(winLen[base] == 1 && winFirst[base] == 8'h06, {"R9 preamble ", tag},
          winFirst[base], 8'h06);
    check(winLen[base + 1] == n + 4, {"R4 frame length ", tag}, winLen[base + 1], n + 4);
    check(capBuf[0] == op, {"R5 opcode ", tag}, capBuf[0], op);
    check({capBuf[1], capBuf[2], capBuf[3]} == addr, {"R6 address ", tag},
          {capBuf[1], capBuf[2], capBuf[3]}, addr);
    begin
      int bad;
      int firstBad;
      bad = 0;
      firstBad = 0;
      for (int i = 0; i < n; i++) begin
        if (capBuf[4 + i] !== patt(seed, i)) begin
          if (bad == 0) firstBad = i;
          bad++;
        end
      end
      check(bad == 0, {"R3/R10 data bytes ", tag}, capBuf[4 + firstBad], patt(seed, firstBad));
    end
    if (meddle) begin
      rd(8'h71, m);
      check(m == 8'(n - 1), {"R12 length untouched ", tag}, m, n - 1);
      rd(8'h6D, m);
      check(m == op, {"R12 opcode untouched ", tag}, m, op);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testStartWithoutIsp();
    runPage(256, 8'h02, 24'h12_34_00, 3, 1'b0, "full page");
    runPage(5, 8'h32, 24'hA5_5A_00, 40, 1'b1, "short page with busy writes");
    runPage(1, 8'h02, 24'hFF_01_00, 77, 1'b0, "single byte");
    check(modeViol == 0, "R11 serial timing", modeViol, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule